// File: doc/BRIEF.md
# Debug breakpoint and watchpoint unit

This block sits beside a CPU core and compares two event streams against a small bank of programmable debug slots. The first is the fetch program counter of the instruction about to execute. The second is the data-memory access stream. Each breakpoint slot holds an instruction address and an enable bit. Each watchpoint slot holds a byte address and a two-bit arming type.

When an enabled breakpoint address equals the fetch PC, the block raises a breakpoint exception request. When an armed watchpoint matches a data access of the right direction, the block raises a separate watchpoint exception request. In that same cycle it drives a stall so that the pipeline can suppress the access before it completes.

A sticky per-slot status vector records every match. Software clears it by writing ones to the bits it wants cleared. All slots are programmed through a simple register-write port. The port selects a register kind and a slot index.

Top module: `dbg_match_unit`

## Requirements
- R1: Out of reset, every breakpoint is disabled, every watchpoint type is disabled (code 0), the status vector is zero, and no request or stall is raised for any input.
- R2: `bp_req` is high in the same cycle that `fetch_valid` is high and `fetch_pc` equals the address of an enabled breakpoint slot. A slot whose enable bit is clear never matches.
- R3: The watchpoint type codes are 0 = disabled, 1 = reads only, 2 = writes only and 3 = reads and writes. A read has `acc_write`=0 and a write has `acc_write`=1. A slot matches only accesses of a direction its type arms.
- R4: A watchpoint whose type is 0 never produces a hit, whatever address its register holds.
- R5: A match requires all `AW` address bits to be equal. A watchpoint covers exactly one byte, so the neighbouring address misses.
- R6: `acc_stall` and `wp_req` are high combinationally in the same cycle as the matching access, before the access completes.
- R7: When a breakpoint and a watchpoint match in the same cycle, only `wp_req` is raised and `bp_req` stays low.
- R8: Each match sets its sticky status bit at the next clock edge. Bit i (i < NUM_BP) belongs to breakpoint i, and bit NUM_BP+j belongs to watchpoint j. A suppressed breakpoint match still sets its bit.
- R9: A write of kind 3 clears the status bits given as ones in `cfg_wdata`. A bit that is set by a match in the same cycle stays set.
- R10: With `fetch_valid` low no breakpoint matches, and with `acc_valid` low no watchpoint matches.
- R11: The register-write port is decoded by `cfg_kind`:
  - Kind 0 loads the breakpoint address of slot `cfg_slot`.
  - Kind 1 loads the watchpoint address of slot `cfg_slot`.
  - Kind 2 loads the slot's breakpoint enable from `cfg_wdata[0]` and the slot's watchpoint type from `cfg_wdata[2:1]`.
  - A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 2 | Register kind: 0 bp addr, 1 wp addr, 2 control, 3 status clear |
| cfg_slot | input | SW | Slot index |
| cfg_wdata | input | AW | Write data |
| fetch_valid | input | 1 | Fetch PC valid |
| fetch_pc | input | AW | PC of instruction about to execute |
| acc_valid | input | 1 | Data access valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Data access byte address |
| bp_req | output | 1 | Breakpoint exception request |
| wp_req | output | 1 | Watchpoint exception request |
| acc_stall | output | 1 | Hold off the current data access |
| hit_status | output | NUM_BP+NUM_WP | Sticky per-slot hit bits |

## Verification
The assertions take three things for granted:
- reset is applied before use;
- `acc_write` is meaningful whenever `acc_valid` is high;
- a status-clear write carries the desired mask in the low bits of `cfg_wdata`.

The stimulus keeps within these assumptions. Every input changes just after a falling edge. Configuration writes last exactly one cycle. Before any check of the status bits, the status is cleared while fetch and access inputs are idle, so that each expected vector follows from that check's stimulus alone.

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int AW = 32,
  localparam int NS = NUM_BP + NUM_WP,
  localparam int MAXS = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
  localparam int SW = (MAXS > 1) ? $clog2(MAXS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_kind,
  input  logic [SW-1:0] cfg_slot,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  output logic          bp_req,
  output logic          wp_req,
  output logic          acc_stall,
  output logic [NS-1:0] hit_status
);

  logic [NUM_BP-1:0] bp_match;
  logic [NUM_WP-1:0] wp_match;
  logic [NUM_WP-1:0] wp_armed_any;
  logic [NS-1:0]     clr_mask;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic [AW-1:0] addr_q;
    logic          en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        en_q   <= 1'b0;
      end else if (cfg_we && cfg_slot == SW'(i)) begin
        if (cfg_kind == 2'd0) addr_q <= cfg_wdata;
        if (cfg_kind == 2'd2) en_q <= cfg_wdata[0];
      end
    end
    assign bp_match[i] = en_q & fetch_valid & (fetch_pc == addr_q);
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    logic [AW-1:0] addr_q;
    logic [1:0]    type_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        type_q <= 2'd0;
      end else if (cfg_we && cfg_slot == SW'(j)) begin
        if (cfg_kind == 2'd1) addr_q <= cfg_wdata;
        if (cfg_kind == 2'd2) type_q <= cfg_wdata[2:1];
      end
    end
    assign wp_armed_any[j] = |type_q;
    assign wp_match[j] = acc_valid & (acc_write ? type_q[1] : type_q[0]) &
                         (acc_addr == addr_q);
  end

  assign wp_req    = |wp_match;
  assign acc_stall = wp_req;
  assign bp_req    = (|bp_match) & ~wp_req;
  assign clr_mask  = (cfg_we && cfg_kind == 2'd3) ? cfg_wdata[NS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_status <= '0;
    else        hit_status <= (hit_status & ~clr_mask) | {wp_match, bp_match};
  end

  assert_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_req && wp_req));
  assert_fetch_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !bp_req);
  assert_acc_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stall |-> acc_valid);
  assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wp_req |-> (|wp_armed_any));
  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_req |=> (hit_status[NS-1:NUM_BP] != '0));
  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_kind == 2'd3) |=> ((hit_status & $past(hit_status)) == $past(hit_status)));

endmodule

// File: tb/dbg_match_unit_test.sv
module dbg_match_unit_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_kind = 0;
  logic [1:0] cfg_slot = 0;
  logic [31:0] cfg_wdata = 0;
  logic fetch_valid = 0;
  logic [31:0] fetch_pc = 0;
  logic acc_valid = 0;
  logic acc_write = 0;
  logic [31:0] acc_addr = 0;
  logic bp_req, wp_req, acc_stall;
  logic [7:0] hit_status;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dbg_match_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_slot(cfg_slot), .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .bp_req(bp_req), .wp_req(wp_req),
    .acc_stall(acc_stall), .hit_status(hit_status));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] k, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_kind = k; cfg_slot = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    fetch_valid = 0; acc_valid = 0; acc_write = 0;
  endtask

  task automatic access(logic w, logic [31:0] a, logic exp_hit, string req);
    @(negedge clk);
    fetch_valid = 0; acc_valid = 1; acc_write = w; acc_addr = a;
    #2;
    check(req, {30'd0, acc_stall, wp_req}, {30'd0, exp_hit, exp_hit});
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 status", {24'd0, hit_status}, 0);
    fetch_valid = 1; fetch_pc = 0; acc_valid = 1; acc_addr = 0; acc_write = 0;
    #2;
    check("R1 no bp", {31'd0, bp_req}, 0);
    check("R1 R4 no wp read", {31'd0, wp_req}, 0);
    acc_write = 1;
    #2;
    check("R1 R4 no wp write", {30'd0, wp_req, acc_stall}, 0);
    idle();
  endtask

  task automatic t_bp();
    cfg(2'd0, 2'd1, 32'h1000);
    @(negedge clk);
    fetch_valid = 1; fetch_pc = 32'h1000;
    #2;
    check("R2 disabled slot", {31'd0, bp_req}, 0);
    idle();
    cfg(2'd2, 2'd1, 32'h1);
    @(negedge clk);
    fetch_valid = 1; fetch_pc = 32'h1004;
    #2;
    check("R5 bp neighbour", {31'd0, bp_req}, 0);
    fetch_valid = 0; fetch_pc = 32'h1000;
    #2;
    check("R10 fetch invalid", {31'd0, bp_req}, 0);
    fetch_valid = 1;
    #2;
    check("R2 R11 bp hit", {31'd0, bp_req}, 1);
    idle();
    check("R8 bp sticky", {24'd0, hit_status}, 32'h02);
  endtask

  task automatic t_wp();
    cfg(2'd1, 2'd0, 32'h2000); cfg(2'd2, 2'd0, 32'h2);
    cfg(2'd1, 2'd2, 32'h3000); cfg(2'd2, 2'd2, 32'h4);
    cfg(2'd1, 2'd3, 32'h4000); cfg(2'd2, 2'd3, 32'h6);
    access(0, 32'h2000, 1, "R3 R6 read type read");
    access(1, 32'h2000, 0, "R3 read type write");
    access(0, 32'h2001, 0, "R5 wp neighbour");
    access(1, 32'h3000, 1, "R3 write type write");
    access(0, 32'h3000, 0, "R3 write type read");
    access(0, 32'h4000, 1, "R3 both type read");
    access(1, 32'h4000, 1, "R3 both type write");
    cfg(2'd2, 2'd3, 32'h0);
    access(0, 32'h4000, 0, "R4 disabled read");
    access(1, 32'h4000, 0, "R4 disabled write");
    @(negedge clk);
    acc_valid = 0; acc_addr = 32'h2000;
    #2;
    check("R10 access invalid", {31'd0, wp_req}, 0);
  endtask

  task automatic t_status_and_priority();
    cfg(2'd3, 2'd0, 32'hFF);
    check("R9 clear all", {24'd0, hit_status}, 0);
    @(negedge clk);
    fetch_valid = 1; fetch_pc = 32'h1000;
    acc_valid = 1; acc_write = 0; acc_addr = 32'h2000;
    #2;
    check("R7 bp suppressed", {31'd0, bp_req}, 0);
    check("R7 wp wins", {31'd0, wp_req}, 1);
    idle();
    check("R8 both sticky", {24'd0, hit_status}, 32'h12);
    @(negedge clk);
    fetch_valid = 1; fetch_pc = 32'h1000;
    cfg_we = 1; cfg_kind = 2'd3; cfg_wdata = 32'h12;
    @(negedge clk);
    cfg_we = 0; fetch_valid = 0;
    check("R9 set beats clear", {24'd0, hit_status}, 32'h02);
    cfg(2'd3, 2'd0, 32'h02);
    check("R9 w1c", {24'd0, hit_status}, 0);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bp();
    t_wp();
    t_status_and_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule